// File: doc/BRIEF.md
# Prescaled Up/Down General-Purpose Timer

A 16-bit counter driven from one synchronous clock through a selectable prescaler. It counts up or down, either reloading a programmable value (periodic mode) or wrapping through the whole range (free-running mode). When the counter passes its end value it raises a sticky timeout flag. A rising edge on a single event input records the current count in a capture register and raises a sticky capture flag. The interrupt output is the OR of the two flags. Software clears each flag by writing a one to its bit in a separate clear register.

Software reaches the block through a simple register bus. A write takes effect on the clock edge where the write strobe is high. Read data is combinational from the address. The register offsets (word addresses) are: 0 control, 1 load value, 2 current count (read-only), 3 capture (read-only) and 4 flag clear (write-only, reads as zero). The control word layout is: bit 15 divide-by-one override, bit 4 enable, bit 3 mode (1 = periodic), bit 2 direction (1 = up) and bits [1:0] prescaler code.

Top module: `gp_timer16`

## Requirements
- R1: After reset the control register reads 0x000A (disabled, periodic, count down, prescaler code 10). The load, count and capture registers read 0x0000, and irq_out is 0.
- R2: While the enable bit (control bit 4) is 0, the count stays at its start value and does not change. In periodic mode (bit 3 = 1) the start value is the load value. In free-running mode it is 0x0000 when counting up (bit 2 = 1) and 0xFFFF when counting down.
- R3: With control bit 2 = 1 the count increments by one on each prescaled tick. With bit 2 = 0 it decrements by one.
- R4: Prescaler code (control bits [1:0]) 00 divides by 1 when control bit 15 is 1 and by 4 when it is 0. Code 01 divides by 16, 10 by 64 and 11 by 256. The first count happens one full division period after the edge that sets enable.
- R5: In periodic mode, a tick that finds the count at its end value (0x0000 when counting down, 0xFFFF when counting up) reloads the load value and sets the timeout flag.
- R6: In free-running mode, a tick at the end value wraps the count (0x0000 to 0xFFFF down, 0xFFFF to 0x0000 up) and sets the timeout flag.
- R7: A rising edge on evt_in copies the count in effect at that clock edge into the capture register (offset 3) and sets the capture flag. Holding evt_in high makes no further capture.
- R8: Writing the clear register (offset 4) with bit 0 = 1 clears the timeout flag, and with bit 1 = 1 clears the capture flag. Zero bits have no effect, and the register reads as 0x0000.
- R9: irq_out is 1 exactly when either flag is set. If a flag's clear and a new event for that flag fall on the same edge, the flag stays set.
- R10: Writing enable to 0 while counting returns the count to its start value on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| evt_in | input | 1 | Capture event input |
| irq_out | output | 1 | Interrupt, OR of the timeout and capture flags |

## Verification
The bench targets the prescaler boundaries. A design that selects /4 instead of /1 for code 00 with the override set, or that counts on the first cycle after enable, leaves the count wrong after an exact number of cycles. It also drives the count into its end value in both periodic directions and through a full 65536-tick free-running wrap. A design that reloads or wraps one tick early or late shows a wrong count, or a timeout flag at the wrong time. Finally, it holds the event input high after a capture and lands a clear on the same edge as a new capture event. A design with a level-sensitive capture, or with a clear that beats the event, drops or re-raises the interrupt at the wrong time.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

   // register word addresses
   localparam logic [2:0] A_CTRL  = 3'd0;
   localparam logic [2:0] A_LOAD  = 3'd1;
   localparam logic [2:0] A_COUNT = 3'd2;
   localparam logic [2:0] A_CAPT  = 3'd3;
   localparam logic [2:0] A_CLR   = 3'd4;

   // control word bit positions (software-visible layout)
   localparam int B_DIV1 = 15;
   localparam int B_EN   = 4;
   localparam int B_PER  = 3;
   localparam int B_UP   = 2;

   localparam int PS_W = 8;

   typedef struct packed {
      logic       div1;
      logic       en;
      logic       periodic;
      logic       up;
      logic [1:0] pre;
   } ctrl_t;

   localparam ctrl_t CTRL_RST = '{div1: 1'b0, en: 1'b0, periodic: 1'b1, up: 1'b0, pre: 2'b10};

   function automatic ctrl_t ctrl_unpack(input logic [15:0] w);
      ctrl_t c;
      c.div1     = w[B_DIV1];
      c.en       = w[B_EN];
      c.periodic = w[B_PER];
      c.up       = w[B_UP];
      c.pre      = w[1:0];
      return c;
   endfunction

   function automatic logic [15:0] ctrl_pack(input ctrl_t c);
      logic [15:0] w;
      w         = '0;
      w[B_DIV1] = c.div1;
      w[B_EN]   = c.en;
      w[B_PER]  = c.periodic;
      w[B_UP]   = c.up;
      w[1:0]    = c.pre;
      return w;
   endfunction

   // terminal value of the prescale counter (divisor minus one)
   function automatic logic [PS_W-1:0] pre_term(input ctrl_t c);
      case (c.pre)
         2'b00:   pre_term = c.div1 ? PS_W'(0) : PS_W'(3);
         2'b01:   pre_term = PS_W'(15);
         2'b10:   pre_term = PS_W'(63);
         default: pre_term = PS_W'(255);
      endcase
   endfunction

endpackage

// File: rtl/gpt_regs.sv
module gpt_regs
   import gpt_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [2:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output ctrl_t             ctrl_q,
   output ctrl_t             ctrl_nx,
   output logic [CNT_W-1:0]  load_q,
   output logic [CNT_W-1:0]  load_nx,
   output logic              clr_to,
   output logic              clr_cap
);

   logic wr_ctrl, wr_load, wr_clr;

   assign wr_ctrl = we && (addr == A_CTRL);
   assign wr_load = we && (addr == A_LOAD);
   assign wr_clr  = we && (addr == A_CLR);

   // next-state values are exported so the counter sees a write on its own edge
   assign ctrl_nx = wr_ctrl ? ctrl_unpack(wdata[15:0]) : ctrl_q;
   assign load_nx = wr_load ? wdata[CNT_W-1:0] : load_q;

   assign clr_to  = wr_clr && wdata[0];
   assign clr_cap = wr_clr && wdata[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
         load_q <= '0;
      end else begin
         ctrl_q <= ctrl_nx;
         load_q <= load_nx;
      end
   end

endmodule

// File: rtl/gpt_prescaler.sv
module gpt_prescaler
   import gpt_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [PS_W-1:0] term,
   output logic            tick
);

   logic [PS_W-1:0] pcnt;
   logic            at_term;

   // >= keeps the divider sane if the code shrinks while running
   assign at_term = (pcnt >= term);
   assign tick    = en && at_term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pcnt <= '0;
      else if (!en)     pcnt <= '0;
      else if (at_term) pcnt <= '0;
      else              pcnt <= pcnt + PS_W'(1);
   end

   // R4
   pre_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (pcnt == '0));
   // R4
   pre_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (pcnt == '0));

endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             up,
   input  logic             periodic,
   input  logic [CNT_W-1:0] load,
   input  logic             nx_en,
   input  logic             nx_up,
   input  logic             nx_periodic,
   input  logic [CNT_W-1:0] nx_load,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt_q,
   output logic             timeout
);

   logic [CNT_W-1:0] start_nx, wrap_val;
   logic             at_end, run;

   assign start_nx = nx_periodic ? nx_load : (nx_up ? '0 : '1);
   assign wrap_val = periodic ? load : (up ? '0 : '1);
   assign at_end   = up ? (&cnt_q) : ~(|cnt_q);
   assign run      = en && nx_en;
   assign timeout  = run && tick && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!run)    cnt_q <= start_nx;
      else if (timeout) cnt_q <= wrap_val;
      else if (tick)    cnt_q <= up ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
   end

   // R3
   step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && up && !at_end) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
   // R3
   step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !up && !at_end) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(cnt_q));
   // R5
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout && periodic) |=> (cnt_q == $past(load)));

endmodule

// File: rtl/gpt_events.sv
module gpt_events #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             timeout_i,
   input  logic             clr_to,
   input  logic             clr_cap,
   output logic [CNT_W-1:0] cap_q,
   output logic             irq
);

   logic evt_d, rise, to_flag, cap_flag;

   assign rise = evt_i && !evt_d;
   assign irq  = to_flag || cap_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_d    <= 1'b0;
         cap_q    <= '0;
         to_flag  <= 1'b0;
         cap_flag <= 1'b0;
      end else begin
         evt_d    <= evt_i;
         if (rise) cap_q <= cnt_i;
         // a new event outranks a clear on the same edge
         to_flag  <= timeout_i || (to_flag && !clr_to);
         cap_flag <= rise || (cap_flag && !clr_cap);
      end
   end

   // R7
   cap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> (cap_flag && cap_q == $past(cnt_i)));
   // R9
   to_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_i |=> irq);
   // R8
   cap_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_cap && !rise) |=> !cap_flag);
   // R8
   to_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_to && !timeout_i) |=> !to_flag);

endmodule

// File: rtl/gp_timer16.sv
module gp_timer16
   import gpt_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [2:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              evt_in,
   output logic              irq_out
);

   localparam int PAD_W = DATA_W - CNT_W;

   if (DATA_W < 16) begin : g_bad_data
      $error("gp_timer16: DATA_W must hold the 16-bit control word");
   end
   if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt
      $error("gp_timer16: CNT_W must be in 2..DATA_W");
   end

   ctrl_t            ctrl_q, ctrl_nx;
   logic [CNT_W-1:0] load_q, load_nx, cnt_q, cap_q;
   logic             clr_to, clr_cap, tick, timeout;
   logic [DATA_W-1:0] cnt_rd, cap_rd, load_rd, ctrl_rd;

   gpt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .ctrl_q(ctrl_q), .ctrl_nx(ctrl_nx), .load_q(load_q), .load_nx(load_nx),
      .clr_to(clr_to), .clr_cap(clr_cap)
   );

   gpt_prescaler u_pre (
      .clk(clk), .rst_n(rst_n), .en(ctrl_q.en && ctrl_nx.en),
      .term(pre_term(ctrl_q)), .tick(tick)
   );

   gpt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .en(ctrl_q.en), .up(ctrl_q.up), .periodic(ctrl_q.periodic), .load(load_q),
      .nx_en(ctrl_nx.en), .nx_up(ctrl_nx.up), .nx_periodic(ctrl_nx.periodic),
      .nx_load(load_nx), .tick(tick), .cnt_q(cnt_q), .timeout(timeout)
   );

   gpt_events #(.CNT_W(CNT_W)) u_evt (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_in), .cnt_i(cnt_q), .timeout_i(timeout),
      .clr_to(clr_to), .clr_cap(clr_cap), .cap_q(cap_q), .irq(irq_out)
   );

   // zero-extend counter-width values onto the bus
   if (PAD_W > 0) begin : g_pad
      assign cnt_rd  = {{PAD_W{1'b0}}, cnt_q};
      assign cap_rd  = {{PAD_W{1'b0}}, cap_q};
      assign load_rd = {{PAD_W{1'b0}}, load_q};
   end else begin : g_nopad
      assign cnt_rd  = cnt_q;
      assign cap_rd  = cap_q;
      assign load_rd = load_q;
   end

   if (DATA_W > 16) begin : g_ctrl_pad
      assign ctrl_rd = {{(DATA_W-16){1'b0}}, ctrl_pack(ctrl_q)};
   end else begin : g_ctrl_nopad
      assign ctrl_rd = ctrl_pack(ctrl_q);
   end

   always_comb begin
      case (bus_addr)
         A_CTRL:  bus_rdata = ctrl_rd;
         A_LOAD:  bus_rdata = load_rd;
         A_COUNT: bus_rdata = cnt_rd;
         A_CAPT:  bus_rdata = cap_rd;
         default: bus_rdata = '0;
      endcase
   end

   // R10
   disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.en && !ctrl_nx.en && !ctrl_nx.periodic && ctrl_nx.up) |=> (cnt_q == '0));

endmodule

// File: tb/gp_timer16_tb.sv
module gp_timer16_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [15:0] bus_wdata = 16'h0;
   logic [15:0] bus_rdata;
   logic        evt_in = 1'b0;
   logic        irq_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   gp_timer16 u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .irq_out(irq_out)
   );

   typedef struct packed {
      logic [15:0] ctrl;
      logic [15:0] load;
      logic [15:0] ncyc;
      logic [15:0] exp_cnt;
      logic        exp_irq;
   } vec_t;

   // ctrl (enable added by the loop), load, cycles after enable, count, irq
   localparam vec_t VECS [9] = '{
      '{16'h8008, 16'h0100, 16'd10,  16'h00F6, 1'b0},  // R4 /1 periodic down
      '{16'h800C, 16'h0010, 16'd5,   16'h0015, 1'b0},  // R3 /1 up
      '{16'h0004, 16'h0000, 16'd9,   16'h0002, 1'b0},  // R4 /4 free up
      '{16'h0001, 16'h0000, 16'd40,  16'hFFFD, 1'b0},  // R4 /16 free down
      '{16'h000A, 16'h0005, 16'd130, 16'h0003, 1'b0},  // R4 /64
      '{16'h0007, 16'h0000, 16'd600, 16'h0002, 1'b0},  // R4 /256
      '{16'h8008, 16'h0003, 16'd4,   16'h0003, 1'b1},  // R5 down reload
      '{16'h800C, 16'hFFFD, 16'd3,   16'hFFFD, 1'b1},  // R5 up reload
      '{16'h8004, 16'h0000, 16'd7,   16'h0007, 1'b0}   // R3 free up /1
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      #1 bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      bus_addr = a;
      #2 d = bus_rdata;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      logic [15:0] d;
      #23 rst_n = 1'b1;
      cyc(1);

      // R1 reset state
      rd(3'd0, d); chk("R1 ctrl", d, 16'h000A);
      rd(3'd1, d); chk("R1 load", d, 16'h0000);
      rd(3'd2, d); chk("R1 count", d, 16'h0000);
      rd(3'd3, d); chk("R1 capture", d, 16'h0000);
      chk("R1 irq", {15'd0, irq_out}, 16'd0);

      // vector table
      for (int i = 0; i < 9; i++) begin
         wr(3'd0, VECS[i].ctrl);
         wr(3'd1, VECS[i].load);
         wr(3'd4, 16'h0003);
         wr(3'd0, VECS[i].ctrl | 16'h0010);
         cyc(int'(VECS[i].ncyc));
         rd(3'd2, d); chk($sformatf("R3/R4/R5 vec%0d count", i), d, VECS[i].exp_cnt);
         chk($sformatf("R5/R9 vec%0d irq", i), {15'd0, irq_out}, {15'd0, VECS[i].exp_irq});
         wr(3'd0, VECS[i].ctrl);
      end
      wr(3'd4, 16'h0003);

      // R2 start values while disabled
      wr(3'd0, 16'h0000); rd(3'd2, d); chk("R2 free down start", d, 16'hFFFF);
      wr(3'd0, 16'h0004); rd(3'd2, d); chk("R2 free up start", d, 16'h0000);
      wr(3'd0, 16'h8008); wr(3'd1, 16'h1234);
      rd(3'd2, d); chk("R2 periodic start", d, 16'h1234);
      cyc(20); rd(3'd2, d); chk("R2 held while disabled", d, 16'h1234);

      // R10 disable mid-count
      wr(3'd0, 16'h8018); cyc(5);
      rd(3'd2, d); chk("R10 running", d, 16'h122F);
      wr(3'd0, 16'h8008);
      rd(3'd2, d); chk("R10 restart on disable", d, 16'h1234);

      // R4 first count a full period after enable (/16)
      wr(3'd1, 16'h0100); wr(3'd0, 16'h0019);
      cyc(15); rd(3'd2, d); chk("R4 no count before period", d, 16'h0100);
      cyc(1);  rd(3'd2, d); chk("R4 first count", d, 16'h00FF);
      wr(3'd0, 16'h0009);

      // R7 capture
      wr(3'd1, 16'h1000); wr(3'd0, 16'h8018);
      cyc(10); rd(3'd2, d); chk("R7 pre-capture count", d, 16'h0FF6);
      evt_in = 1'b1;
      cyc(1);
      rd(3'd3, d); chk("R7 captured value", d, 16'h0FF6);
      chk("R7 capture flag irq", {15'd0, irq_out}, 16'd1);
      wr(3'd4, 16'h0001); chk("R8 other bit leaves capture flag", {15'd0, irq_out}, 16'd1);
      wr(3'd4, 16'h0000); chk("R8 zero write no effect", {15'd0, irq_out}, 16'd1);
      rd(3'd4, d); chk("R8 clear reg reads zero", d, 16'h0000);
      wr(3'd4, 16'h0002); chk("R8 capture flag cleared", {15'd0, irq_out}, 16'd0);
      cyc(5);
      chk("R7 held level no recapture", {15'd0, irq_out}, 16'd0);
      rd(3'd3, d); chk("R7 capture unchanged", d, 16'h0FF6);

      // R9 clear and new event on the same edge
      evt_in = 1'b0; cyc(2);
      @(negedge clk);
      evt_in = 1'b1; bus_addr = 3'd4; bus_wdata = 16'h0002; bus_we = 1'b1;
      @(posedge clk); #1 bus_we = 1'b0;
      chk("R9 event wins over clear", {15'd0, irq_out}, 16'd1);
      evt_in = 1'b0;
      wr(3'd0, 16'h8008); wr(3'd4, 16'h0003);
      chk("R9 irq low after both cleared", {15'd0, irq_out}, 16'd0);

      // R6 full free-running wrap, down, /1
      wr(3'd0, 16'h8010);
      cyc(65535);
      rd(3'd2, d); chk("R6 reached zero", d, 16'h0000);
      chk("R6 no timeout yet", {15'd0, irq_out}, 16'd0);
      cyc(1);
      rd(3'd2, d); chk("R6 wrapped", d, 16'hFFFF);
      chk("R6 timeout flag", {15'd0, irq_out}, 16'd1);
      wr(3'd0, 16'h8000);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule